// File: doc/BRIEF.md
# Serial Clock Synthesizer Programming Shifter

This block programs an external frequency synthesizer over a three-wire serial link made of a select strobe, a data line and a clock line. A single-cycle load request latches five divider fields (N, M, V, X and R) and a phase-length setting. The block then produces one complete programming frame and releases the link.

The frame runs as follows. Select is raised with data and clock low. Select then falls. Twenty-four bits follow, least significant bit first within each field. N (7 bits) goes first, then M (7), V (1), X (2) and R (2). A fixed 5-bit trailer of value 0x17 closes the frame. When the last bit is done, all three output enables drop.

Each protocol phase lasts `phase_div + 1` system clock cycles, so one programmable value sets the serial rate. Typical settings are N=120, M=100, V=1, X=1, R=2 for a 1.5 MHz output, and N=80, M=125, V=1, X=3, R=3 for 100 kHz.

Top module: `synth_prog_shifter`

## Requirements
- R1: After a synchronous reset, `busy`, all three lines and all three output enables are 0. A reset in the middle of a frame abandons that frame.
- R2: An accepted request starts with one phase of select high (data and clock low), then one phase of select low. Select stays low for every bit phase after that.
- R3: The 24 frame bits go out in this order: N[0..6], M[0..6], V[0], X[0..1], R[0..1], then the trailer. Each field is sent least significant bit first.
- R4: The trailer is the constant 0x17, sent as the bit sequence 1,1,1,0,1.
- R5: Each bit takes three phases. In the first, clock is low and data carries the bit. In the second, clock is high. In the third, clock is low again. Data holds the same value across all three.
- R6: The three output enables are high exactly while `busy` is high. While they are low, all three lines are driven to 0.
- R7: Every phase lasts `phase_div + 1` cycles, using the `phase_div` value sampled at the accepted request. A frame therefore lasts 74 × (`phase_div` + 1) cycles.
- R8: `busy` rises in the cycle after the accepted request and falls when the frame ends. Any `load_req` seen while `busy` is high is ignored. A request held high across the end of a frame starts the next frame on the first idle cycle.
- R9: The parameter fields are captured at the accepted request. Changing them during the frame has no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Start a frame (taken only when idle) |
| phase_div | input | DIV_W | Phase length minus one, in clock cycles |
| n_val | input | N_W | N divider field |
| m_val | input | M_W | M divider field |
| v_val | input | V_W | V field |
| x_val | input | X_W | X field |
| r_val | input | R_W | R field |
| busy | output | 1 | Frame in progress |
| sel_o | output | 1 | Select strobe level |
| sel_oe | output | 1 | Select output enable |
| dat_o | output | 1 | Serial data level |
| dat_oe | output | 1 | Serial data output enable |
| sck_o | output | 1 | Serial clock level |
| sck_oe | output | 1 | Serial clock output enable |

## Verification
The bench builds the block with its default widths: 7/7/1/2/2 fields, a 5-bit trailer and an 8-bit phase divider. This gives the real 24-bit frame. Frames are run with `phase_div` at 0, 1 and 2. Single-cycle phases expose any off-by-one in the phase transitions. Stretched phases show that the divider value is sampled at the request and that the data line holds steady across a clock pulse. With these settings, back-to-back frames, parameter changes and load requests in the middle of a frame, and a reset in the middle of a frame all fit in a few hundred cycles each.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL_HI,
    PH_SEL_LO,
    PH_BIT_SETUP,
    PH_BIT_HIGH,
    PH_BIT_HOLD
  } phase_e;

  typedef struct packed {
    logic en;
    logic sel;
    logic dat;
    logic sck;
  } pins_t;

endpackage

// File: rtl/synth_frame_pack.sv
module synth_frame_pack #(
  parameter int N_W     = 7,
  parameter int M_W     = 7,
  parameter int V_W     = 1,
  parameter int X_W     = 2,
  parameter int R_W     = 2,
  parameter int TRL_W   = 5,
  parameter int TRL_VAL = 'h17,
  localparam int FRAME_W = N_W + M_W + V_W + X_W + R_W + TRL_W
) (
  input  logic [N_W-1:0]     n_val,
  input  logic [M_W-1:0]     m_val,
  input  logic [V_W-1:0]     v_val,
  input  logic [X_W-1:0]     x_val,
  input  logic [R_W-1:0]     r_val,
  output logic [FRAME_W-1:0] frame
);
  localparam logic [TRL_W-1:0] TRAILER = TRL_W'(TRL_VAL);

  // bit 0 leaves first, so the first field sits in the low bits
  assign frame = {TRAILER, r_val, x_val, v_val, m_val, n_val};

endmodule

// File: rtl/synth_phase_timer.sv
module synth_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = active && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !active || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int DIV_W   = 8,
  localparam int CNT_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_req,
  input  logic [FRAME_W-1:0] frame,
  input  logic [DIV_W-1:0]   div_in,
  input  logic               tick,
  output logic               active,
  output logic [DIV_W-1:0]   div_lim,
  output logic               busy,
  output pins_t              pins
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  phase_e             state_q, state_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic [DIV_W-1:0]   div_q, div_d;
  pins_t              pins_q, pins_d;
  logic               busy_q;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    bit_d   = bit_q;
    div_d   = div_q;
    case (state_q)
      PH_IDLE:
        if (load_req) begin
          state_d = PH_SEL_HI;
          shreg_d = frame;
          div_d   = div_in;
          bit_d   = '0;
        end
      PH_SEL_HI:    if (tick) state_d = PH_SEL_LO;
      PH_SEL_LO:    if (tick) state_d = PH_BIT_SETUP;
      PH_BIT_SETUP: if (tick) state_d = PH_BIT_HIGH;
      PH_BIT_HIGH:  if (tick) state_d = PH_BIT_HOLD;
      PH_BIT_HOLD:
        if (tick) begin
          if (bit_q == LAST_BIT) begin
            state_d = PH_IDLE;
          end else begin
            state_d = PH_BIT_SETUP;
            bit_d   = bit_q + 1'b1;
            shreg_d = shreg_q >> 1;
          end
        end
      default: state_d = PH_IDLE;
    endcase
  end

  always_comb begin
    pins_d.en  = (state_d != PH_IDLE);
    pins_d.sel = (state_d == PH_SEL_HI);
    pins_d.sck = (state_d == PH_BIT_HIGH);
    pins_d.dat = shreg_d[0] && ((state_d == PH_BIT_SETUP) ||
                                (state_d == PH_BIT_HIGH)  ||
                                (state_d == PH_BIT_HOLD));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      div_q   <= '0;
      pins_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      bit_q   <= bit_d;
      div_q   <= div_d;
      pins_q  <= pins_d;
      busy_q  <= (state_d != PH_IDLE);
    end
  end

  assign active  = (state_q != PH_IDLE);
  assign div_lim = div_q;
  assign busy    = busy_q;
  assign pins    = pins_q;

endmodule

// File: rtl/synth_prog_shifter.sv
module synth_prog_shifter
  import synth_prog_pkg::*;
#(
  parameter int N_W     = 7,
  parameter int M_W     = 7,
  parameter int V_W     = 1,
  parameter int X_W     = 2,
  parameter int R_W     = 2,
  parameter int TRL_W   = 5,
  parameter int TRL_VAL = 'h17,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_req,
  input  logic [DIV_W-1:0] phase_div,
  input  logic [N_W-1:0]   n_val,
  input  logic [M_W-1:0]   m_val,
  input  logic [V_W-1:0]   v_val,
  input  logic [X_W-1:0]   x_val,
  input  logic [R_W-1:0]   r_val,
  output logic             busy,
  output logic             sel_o,
  output logic             sel_oe,
  output logic             dat_o,
  output logic             dat_oe,
  output logic             sck_o,
  output logic             sck_oe
);
  localparam int FRAME_W = N_W + M_W + V_W + X_W + R_W + TRL_W;

  logic [FRAME_W-1:0] frame;
  logic               tick;
  logic               active;
  logic [DIV_W-1:0]   div_lim;
  pins_t              pins;

  synth_frame_pack #(
    .N_W(N_W), .M_W(M_W), .V_W(V_W), .X_W(X_W), .R_W(R_W),
    .TRL_W(TRL_W), .TRL_VAL(TRL_VAL)
  ) u_pack (
    .n_val(n_val), .m_val(m_val), .v_val(v_val),
    .x_val(x_val), .r_val(r_val), .frame(frame)
  );

  synth_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .active(active), .limit(div_lim), .tick(tick)
  );

  synth_prog_seq #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst(rst), .load_req(load_req), .frame(frame),
    .div_in(phase_div), .tick(tick), .active(active), .div_lim(div_lim),
    .busy(busy), .pins(pins)
  );

  assign sel_o  = pins.sel;
  assign dat_o  = pins.dat;
  assign sck_o  = pins.sck;
  assign sel_oe = pins.en;
  assign dat_oe = pins.en;
  assign sck_oe = pins.en;

endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic sel_o,
  input logic sel_oe,
  input logic dat_o,
  input logic dat_oe,
  input logic sck_o,
  input logic sck_oe
);
  // R6
  oe_match_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_oe == busy) && (dat_oe == busy) && (sck_oe == busy));

  // R6
  idle_lines_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sel_o && !dat_o && !sck_o));

  // R2
  start_sel_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (sel_o && !dat_o && !sck_o));

  // R2
  sel_low_on_clock_chk: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> !sel_o);

  // R5
  data_stable_clock_chk: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> $stable(dat_o));

  // R5
  clock_ends_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(sck_o));

endmodule

bind synth_prog_shifter synth_prog_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy),
  .sel_o(sel_o), .sel_oe(sel_oe),
  .dat_o(dat_o), .dat_oe(dat_oe),
  .sck_o(sck_o), .sck_oe(sck_oe)
);

// File: tb/synth_prog_shifter_test.sv
`timescale 1ns/1ps
module synth_prog_shifter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_req = 1'b0;
  logic [7:0] phase_div = '0;
  logic [6:0] n_val = '0;
  logic [6:0] m_val = '0;
  logic [0:0] v_val = '0;
  logic [1:0] x_val = '0;
  logic [1:0] r_val = '0;
  logic busy, sel_o, sel_oe, dat_o, dat_oe, sck_o, sck_oe;

  int vectors = 0;
  int fails = 0;
  bit started = 0;
  string tag = "R1";

  // expected entry: {busy, sel, dat, sck}
  logic [3:0] q[$];
  logic [3:0] cur = '0;

  always #2 clk = ~clk;

  synth_prog_shifter uut (
    .clk(clk), .rst(rst), .load_req(load_req), .phase_div(phase_div),
    .n_val(n_val), .m_val(m_val), .v_val(v_val), .x_val(x_val), .r_val(r_val),
    .busy(busy), .sel_o(sel_o), .sel_oe(sel_oe), .dat_o(dat_o),
    .dat_oe(dat_oe), .sck_o(sck_o), .sck_oe(sck_oe)
  );

  task automatic push_phase(input logic [3:0] e, input int len);
    for (int k = 0; k < len; k++) q.push_back(e);
  endtask

  task automatic build_frame();
    logic bits[$];
    int len;
    len = int'(phase_div) + 1;
    for (int i = 0; i < 7; i++) bits.push_back(n_val[i]);
    for (int i = 0; i < 7; i++) bits.push_back(m_val[i]);
    bits.push_back(v_val[0]);
    for (int i = 0; i < 2; i++) bits.push_back(x_val[i]);
    for (int i = 0; i < 2; i++) bits.push_back(r_val[i]);
    bits.push_back(1'b1); bits.push_back(1'b1); bits.push_back(1'b1);
    bits.push_back(1'b0); bits.push_back(1'b1);
    push_phase(4'b1100, len);
    push_phase(4'b1000, len);
    foreach (bits[i]) begin
      push_phase({1'b1, 1'b0, bits[i], 1'b0}, len);
      push_phase({1'b1, 1'b0, bits[i], 1'b1}, len);
      push_phase({1'b1, 1'b0, bits[i], 1'b0}, len);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      q.delete();
      cur = '0;
    end else begin
      if (!cur[3] && load_req) build_frame();
      if (q.size() > 0) cur = q.pop_front();
      else cur = '0;
    end
  end

  task automatic cmp(input string req, input string what, input logic act, input logic exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s phase) %s at %0t: actual %b expected %b", req, tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      cmp("R8", "busy", busy, cur[3]);
      cmp("R2", "sel_o", sel_o, cur[2]);
      cmp("R3 R4", "dat_o", dat_o, cur[1]);
      cmp("R5", "sck_o", sck_o, cur[0]);
      cmp("R6", "sel_oe", sel_oe, cur[3]);
      cmp("R6", "dat_oe", dat_oe, cur[3]);
      cmp("R6", "sck_oe", sck_oe, cur[3]);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start(input int n, input int m, input int v, input int x,
                       input int r, input int d);
    n_val = 7'(n); m_val = 7'(m); v_val = 1'(v); x_val = 2'(x); r_val = 2'(r);
    phase_div = 8'(d);
    load_req = 1'b1;
    step(1);
    load_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      step(1);
      if (!busy) break;
    end
    step(3);
  endtask

  initial begin
    #1;
    tag = "R1";
    step(4);
    rst = 1'b0;
    step(3);

    tag = "R3";
    start(120, 100, 1, 1, 2, 0);
    wait_idle();

    tag = "R7";
    start(80, 125, 1, 3, 3, 2);
    wait_idle();

    tag = "R9";
    start(7'h55, 7'h2A, 0, 2, 1, 1);
    step(20);
    n_val = 7'h7F; m_val = 7'h00; v_val = 1'b1; x_val = 2'b01; r_val = 2'b10;
    phase_div = 8'd5;
    tag = "R8";
    load_req = 1'b1; step(1); load_req = 1'b0;
    step(40);
    load_req = 1'b1; step(2); load_req = 1'b0;
    wait_idle();

    tag = "R4";
    start(0, 0, 0, 0, 0, 0);
    wait_idle();

    tag = "R6";
    n_val = 7'h7F; m_val = 7'h7F; v_val = 1'b1; x_val = 2'b11; r_val = 2'b11;
    phase_div = 8'd0;
    load_req = 1'b1;
    step(160);
    load_req = 1'b0;
    wait_idle();

    tag = "R1";
    start(33, 66, 1, 2, 3, 1);
    step(30);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(5);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule